// File: doc/BRIEF.md
# Programmable Bit-Slice ALU Chain

A purely combinational 8-bit arithmetic and logic unit assembled from identical one-bit slices linked by a ripple carry. No opcode decoder exists: the operation is fixed entirely by three 4-bit truth-table words that every slice receives unchanged. The first word forms a propagate term from the two operand bits, the second forms a kill term from the same bits, and the third forms the result bit from the propagate term and the incoming carry.

Each slice holds three 4-to-1 lookup cells and a carry cell. A lookup cell returns bit `2*x + y` of its table word, where x is the high select and y the low select. Loading suitable words gives addition, bitwise AND, OR, XOR or operand pass-through. The external carry enters bit 0 and the carry leaving bit 7 is the block's carry output. The block has no clock, reset or storage.

Top module: `bitSliceAlu`

## Requirements
- R1: A lookup cell with table word g and selects x (high), y (low) outputs g[2*x+y]: g[0] for x=0,y=0; g[1] for x=0,y=1; g[2] for x=1,y=0; g[3] for x=1,y=1.
- R2: In slice i the propagate term p is the propagate word looked up with x=opA[i], y=opB[i]; the kill term k is the kill word looked up with the same selects.
- R3: The carry leaving a slice is (p AND carry-in) OR (NOT p AND NOT k); with all three words zero and carryIn 0, result is 0 and carryOut is 1.
- R4: The result bit of a slice is the result word looked up with x=p and y=the slice's carry-in.
- R5: The carry out of slice i feeds slice i+1, carryIn feeds slice 0, and the carry out of slice 7 is carryOut; the same three words reach every slice.
- R6: With propagate 4'b0110, kill 4'b0001 and result 4'b0110, {carryOut, result} equals opA + opB + carryIn.
- R7: With propagate 4'b1000, kill 4'b1111, result 4'b1100 and carryIn 0, result equals opA & opB and carryOut is 0.
- R8: With kill 4'b1111, result 4'b1100 and carryIn 0, propagate 4'b1110 gives opA | opB, 4'b0110 gives opA ^ opB and 4'b1100 passes opA through, each with carryOut 0.
- R9: Under the R6 words, all-ones operands with carryIn 1 give result 8'hFF and carryOut 1, and opA all ones, opB zero, carryIn 1 give result 0 and carryOut 1 (carry rippled through every slice).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand, high lookup select for propagate and kill |
| opB | input | 8 | Second operand, low lookup select for propagate and kill |
| carryIn | input | 1 | Carry into slice 0 |
| propCtl | input | 4 | Propagate truth-table word shared by all slices |
| killCtl | input | 4 | Kill truth-table word shared by all slices |
| resCtl | input | 4 | Result truth-table word shared by all slices |
| result | output | 8 | Result bits, one per slice |
| carryOut | output | 1 | Carry leaving slice 7 |

## Verification
The embedded assertions check at every input change that each slice's carry obeys the propagate/kill rule against its own p and k, that the kill term under the addition word matches the operand pattern, and that the whole chain produces the arithmetic sum or the bitwise AND whenever those word sets are applied. The lookup-bit ordering of every cell, the sharing of words across slices and the full carry ripple for other word sets are shown only by the bench, which sweeps all 4096 control combinations against a per-slice model and runs directed addition and logic cases including the long-ripple operands.

// File: rtl/aluSlicePkg.sv
`timescale 1ns/1ps
package aluSlicePkg;
  localparam int CTL_W = 4;

  // Truth-table words delivered from the control side to every slice.
  typedef struct packed {
    logic [CTL_W-1:0] propTbl;
    logic [CTL_W-1:0] killTbl;
    logic [CTL_W-1:0] resTbl;
  } sliceCtlT;

  localparam logic [CTL_W-1:0] ADD_PROP = 4'b0110;
  localparam logic [CTL_W-1:0] ADD_KILL = 4'b0001;
  localparam logic [CTL_W-1:0] ADD_RES  = 4'b0110;
  localparam logic [CTL_W-1:0] AND_PROP = 4'b1000;
  localparam logic [CTL_W-1:0] LOG_KILL = 4'b1111;
  localparam logic [CTL_W-1:0] LOG_RES  = 4'b1100;
endpackage

// File: rtl/lutCell.sv
`timescale 1ns/1ps
module lutCell
  import aluSlicePkg::*;
(
  input  logic [CTL_W-1:0] tbl,
  input  logic             selHi,
  input  logic             selLo,
  output logic             lutOut
);
  // R1: entry index is 2*selHi + selLo
  always_comb begin
    unique case ({selHi, selLo})
      2'b00:   lutOut = tbl[0];
      2'b01:   lutOut = tbl[1];
      2'b10:   lutOut = tbl[2];
      default: lutOut = tbl[3];
    endcase
  end
endmodule

// File: rtl/ctrlRouter.sv
`timescale 1ns/1ps
module ctrlRouter
  import aluSlicePkg::*;
(
  input  logic [CTL_W-1:0] propCtl,
  input  logic [CTL_W-1:0] killCtl,
  input  logic [CTL_W-1:0] resCtl,
  output sliceCtlT         ctlBus
);
  // R5: one bundle, fanned out unchanged to all slices
  always_comb begin
    ctlBus.propTbl = propCtl;
    ctlBus.killTbl = killCtl;
    ctlBus.resTbl  = resCtl;
  end
endmodule

// File: rtl/bitSlice.sv
`timescale 1ns/1ps
module bitSlice
  import aluSlicePkg::*;
(
  input  sliceCtlT ctlBus,
  input  logic     aBit,
  input  logic     bBit,
  input  logic     cIn,
  output logic     rBit,
  output logic     cOut
);
  logic propTerm;
  logic killTerm;

  // R2: propagate and kill lookups selected by the operand bits
  lutCell uProp (
    .tbl   (ctlBus.propTbl),
    .selHi (aBit),
    .selLo (bBit),
    .lutOut(propTerm)
  );

  lutCell uKill (
    .tbl   (ctlBus.killTbl),
    .selHi (aBit),
    .selLo (bBit),
    .lutOut(killTerm)
  );

  // R3: carry rule
  assign cOut = (propTerm & cIn) | (~propTerm & ~killTerm);

  // R4: result lookup selected by propagate and incoming carry
  lutCell uRes (
    .tbl   (ctlBus.resTbl),
    .selHi (propTerm),
    .selLo (cIn),
    .lutOut(rBit)
  );

  always_comb begin
    if (!$isunknown({propTerm, killTerm, cIn, cOut})) begin
      // R3: a propagating slice copies its carry, otherwise carry is the inverted kill
      a_r3_carry_rule: assert (propTerm ? (cOut == cIn) : (cOut == !killTerm))
        else $error("a_r3_carry_rule violated");
    end
    if (!$isunknown({aBit, bBit, killTerm, ctlBus.killTbl})) begin
      // R2: under the addition kill word, kill fires only for two zero bits
      if (ctlBus.killTbl == ADD_KILL) begin
        a_r2_kill_add: assert (killTerm == (!aBit && !bBit))
          else $error("a_r2_kill_add violated");
      end
    end
  end
endmodule

// File: rtl/sliceChain.sv
`timescale 1ns/1ps
module sliceChain
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 8
) (
  input  sliceCtlT         ctlBus,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] carryNet;

  assign carryNet[0] = carryIn;

  // R5: slice i passes its carry to slice i+1
  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    bitSlice uSlice (
      .ctlBus(ctlBus),
      .aBit  (opA[i]),
      .bBit  (opB[i]),
      .cIn   (carryNet[i]),
      .rBit  (result[i]),
      .cOut  (carryNet[i+1])
    );
  end

  assign carryOut = carryNet[WIDTH];

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, result, carryOut, ctlBus})) begin
      // R6: addition words give the arithmetic sum across the whole chain
      if (ctlBus.propTbl == ADD_PROP && ctlBus.killTbl == ADD_KILL &&
          ctlBus.resTbl == ADD_RES) begin
        a_r6_add_sum: assert ({carryOut, result} ==
                              ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
          else $error("a_r6_add_sum violated");
      end
      // R7: AND words with zero carry give the bitwise AND and no carry
      if (ctlBus.propTbl == AND_PROP && ctlBus.killTbl == LOG_KILL &&
          ctlBus.resTbl == LOG_RES && !carryIn) begin
        a_r7_and_result: assert (result == (opA & opB) && !carryOut)
          else $error("a_r7_and_result violated");
      end
    end
  end
endmodule

// File: rtl/bitSliceAlu.sv
`timescale 1ns/1ps
module bitSliceAlu
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [3:0]       propCtl,
  input  logic [3:0]       killCtl,
  input  logic [3:0]       resCtl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  sliceCtlT ctlBus;

  ctrlRouter uCtrl (
    .propCtl(propCtl),
    .killCtl(killCtl),
    .resCtl (resCtl),
    .ctlBus (ctlBus)
  );

  sliceChain #(.WIDTH(WIDTH)) uPath (
    .ctlBus  (ctlBus),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .result  (result),
    .carryOut(carryOut)
  );
endmodule

// File: tb/tb_bitSliceAlu.sv
`timescale 1ns/1ps
module tb_bitSliceAlu;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opA, opB, result;
  logic         carryIn, carryOut;
  logic [3:0]   propCtl, killCtl, resCtl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bitSliceAlu #(.WIDTH(W)) dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .propCtl(propCtl), .killCtl(killCtl), .resCtl(resCtl),
    .result(result), .carryOut(carryOut)
  );

  function automatic logic lut(input logic [3:0] g, input logic x, input logic y);
    return g[{x, y}];
  endfunction

  // Per-slice model built from the lookup, carry and result equations
  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic ci, input logic [3:0] pc,
                                       input logic [3:0] kc, input logic [3:0] rc);
    logic [W-1:0] r;
    logic c;
    c = ci;
    for (int i = 0; i < W; i++) begin
      logic p, k;
      p = lut(pc, a[i], b[i]);
      k = lut(kc, a[i], b[i]);
      r[i] = lut(rc, p, c);
      c = (p & c) | (~p & ~k);
    end
    return {c, r};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                       input logic [3:0] pc, input logic [3:0] kc, input logic [3:0] rc);
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    propCtl = pc; killCtl = kc; resCtl = rc;
    #1;
  endtask

  task automatic check(input string tag, input logic [W:0] expv);
    checks++;
    if ({carryOut, result} !== expv) begin
      failures++;
      $display("FAIL %s: actual {cout,r}=%h expected %h (a=%h b=%h ci=%b p=%b k=%b r=%b)",
               tag, {carryOut, result}, expv, opA, opB, carryIn, propCtl, killCtl, resCtl);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    logic ci;

    // R3: all-zero words and operands, carry generated by every slice
    apply(8'h00, 8'h00, 1'b0, 4'h0, 4'h0, 4'h0);
    check("R3 zero words", {1'b1, 8'h00});

    // R1 R2 R3 R4 R5: every control combination against the slice model
    for (int cw = 0; cw < 4096; cw++) begin
      for (int n = 0; n < 6; n++) begin
        a = W'($urandom);
        b = W'($urandom);
        ci = 1'($urandom);
        apply(a, b, ci, cw[3:0], cw[7:4], cw[11:8]);
        check("R1/R2/R3/R4/R5 model", model(a, b, ci, cw[3:0], cw[7:4], cw[11:8]));
      end
    end

    // R6: addition, arithmetic expectation
    for (int n = 0; n < 300; n++) begin
      a = W'($urandom);
      b = W'($urandom);
      ci = 1'($urandom);
      apply(a, b, ci, 4'b0110, 4'b0001, 4'b0110);
      check("R6 add", {1'b0, a} + {1'b0, b} + {8'h00, ci});
    end

    // R9: full ripple cases
    apply(8'hFF, 8'hFF, 1'b1, 4'b0110, 4'b0001, 4'b0110);
    check("R9 ones+ones+1", 9'h1FF);
    apply(8'hFF, 8'h00, 1'b1, 4'b0110, 4'b0001, 4'b0110);
    check("R9 ones+0+1", 9'h100);
    apply(8'h00, 8'hFF, 1'b1, 4'b0110, 4'b0001, 4'b0110);
    check("R9 0+ones+1", 9'h100);

    // R7: AND; R8: OR, XOR, pass-through
    for (int n = 0; n < 200; n++) begin
      a = W'($urandom);
      b = W'($urandom);
      apply(a, b, 1'b0, 4'b1000, 4'b1111, 4'b1100);
      check("R7 and", {1'b0, a & b});
      apply(a, b, 1'b0, 4'b1110, 4'b1111, 4'b1100);
      check("R8 or", {1'b0, a | b});
      apply(a, b, 1'b0, 4'b0110, 4'b1111, 4'b1100);
      check("R8 xor", {1'b0, a ^ b});
      apply(a, b, 1'b0, 4'b1100, 4'b1111, 4'b1100);
      check("R8 pass a", {1'b0, a});
    end
    apply(8'hFF, 8'hFF, 1'b0, 4'b1000, 4'b1111, 4'b1100);
    check("R7 and ones", 9'h0FF);
    apply(8'hA5, 8'h5A, 1'b0, 4'b0110, 4'b1111, 4'b1100);
    check("R8 xor complement", 9'h0FF);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule